// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache with Per-Set LRU

This block is a small data cache that sits between a processor-side request port and a memory-side port. It holds eight one-word lines, arranged as four sets of two ways. Every accepted access produces a single response. The response says whether the access hit, whether the word is resident after the access, and which line (0 to 7) holds it.

Reads that miss stall the request port. The block sends one fetch to memory and waits for the word. When the word arrives, the block fills the line and returns the word in the same registered response. Writes go straight through to memory. A write that hits also updates the cached word. A write that misses allocates nothing.

Each set keeps one replacement bit. The bit is refreshed on every hit and every fill, so it always names the way that was not just used. When a fill finds both lines of a set empty, the word always goes into the lower-numbered line.

Top module: `cache2w_lru`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0, and every line is empty, so the first access to any address misses.
- R2: The set is the word address modulo 4 and the tag is the remaining upper address bits. `resp_line` reports set*2+way, where way 0 is the lower-numbered line of the set.
- R3: A read that hits returns the cached word with `resp_hit`=1 and `resp_cached`=1 in the cycle after it is accepted, and issues no memory request.
- R4: A read miss holds `req_ready` at 0 from the cycle after acceptance until the fill. It issues a one-cycle read on the memory port with the request address. The response (`resp_hit`=0, `resp_cached`=1, the fetched word) appears in the cycle after `mem_rsp_valid`, and the line is filled at that same edge.
- R5: A fill into a set whose two lines are both empty goes to way 0.
- R6: A fill into a set with exactly one empty line uses that empty line, whatever the replacement bit says.
- R7: A fill into a full set evicts the least recently used way. Every hit and every fill updates the set's replacement bit so that it names the other way.
- R8: A write hit updates the cached word (`resp_hit`=1, `resp_line` of that line). In the next cycle it also issues a memory write of the same address and data.
- R9: A write miss allocates no line. It responds with `resp_hit`=0 and `resp_cached`=0 and issues a memory write, so a later read of that address misses and fetches the written word.
- R10: The reset is synchronous. Asserting it during operation empties every line and clears every replacement bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request port can accept; low while a read miss is pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Access hit |
| resp_cached | output | 1 | Word resides in the cache after the access |
| resp_line | output | SET_W+1 | Line used (set*2+way), valid when resp_cached |
| resp_rdata | output | DATA_W | Read word (or the written word on writes) |
| mem_req_valid | output | 1 | One-cycle memory request |
| mem_req_write | output | 1 | Memory request is a write-through |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Fetched word present |
| mem_rsp_data | input | DATA_W | Fetched word |

## Verification
A wrong valid bit or tag shows up at the very next access to that set. That access reports the wrong `resp_hit` and either raises or omits a memory fetch, one cycle after acceptance. A stale or flipped replacement bit stays hidden until the set is full and misses. It then shows as the wrong `resp_line` on the fill, and as an unexpected miss on the next read of the line that should have survived. The stimulus is therefore ordered so that every set's history is revisited after each eviction.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_FILL = 1'b1
    } mode_e;

    localparam int unsigned WAYS = 2;

endpackage

// File: rtl/cache2w_store.sv
module cache2w_store #(
    parameter int unsigned SETS   = 4,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SET_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic                        wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [SET_W-1:0]            rd_set,
    output logic [1:0]                  rd_valid,
    output logic [1:0][TAG_W-1:0]       rd_tag,
    output logic [1:0][DATA_W-1:0]      rd_data
);

    typedef struct packed {
        logic [SETS-1:0][1:0]              valid;
        logic [SETS-1:0][1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0][1:0][DATA_W-1:0]  data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.valid[wr_set][wr_way] = 1'b1;
            st_d.tag[wr_set][wr_way]   = wr_tag;
            st_d.data[wr_set][wr_way]  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar w = 0; w < 2; w++) begin : g_way_rd
        assign rd_valid[w] = st_q.valid[rd_set][w];
        assign rd_tag[w]   = st_q.tag[rd_set][w];
        assign rd_data[w]  = st_q.data[rd_set][w];
    end

    // R8: a written slot holds the written word on the next cycle
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> st_q.valid[$past(wr_set)][$past(wr_way)] &&
                  st_q.data[$past(wr_set)][$past(wr_way)] == $past(wr_data));

endmodule

// File: rtl/cache2w_lrubits.sv
module cache2w_lrubits #(
    parameter int unsigned SETS = 4,
    localparam int unsigned SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way,
    input  logic [SET_W-1:0] rd_set,
    output logic             evict_way
);

    typedef struct packed {
        logic [SETS-1:0] lru;
    } lru_t;

    lru_t lr_d, lr_q;

    always_comb begin
        lr_d = lr_q;
        if (touch_en) begin
            lr_d.lru[touch_set] = ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lr_q <= '0;
        else     lr_q <= lr_d;
    end

    assign evict_way = lr_q.lru[rd_set];

    // R7: after a touch the set's bit names the other way
    assert_lru_points_away_R7: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> lr_q.lru[$past(touch_set)] != $past(touch_way));

endmodule

// File: rtl/cache2w_lookup.sv
module cache2w_lookup #(
    parameter int unsigned TAG_W = 6
) (
    input  logic [TAG_W-1:0]       tag,
    input  logic [1:0]             rd_valid,
    input  logic [1:0][TAG_W-1:0]  rd_tag,
    input  logic                   lru_way,
    output logic [1:0]             way_hit,
    output logic                   hit,
    output logic                   hit_way,
    output logic                   victim_way
);

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign way_hit[w] = rd_valid[w] && (rd_tag[w] == tag);
    end

    always_comb begin
        hit     = |way_hit;
        hit_way = way_hit[1];
        if (!rd_valid[0])      victim_way = 1'b0;
        else if (!rd_valid[1]) victim_way = 1'b1;
        else                   victim_way = lru_way;
    end

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru
    import cache2w_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SETS   = 4,
    localparam int unsigned SET_W  = $clog2(SETS),
    localparam int unsigned TAG_W  = ADDR_W - SET_W,
    localparam int unsigned LINE_W = SET_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_cached,
    output logic [LINE_W-1:0] resp_line,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    typedef struct packed {
        mode_e             mode;
        logic [ADDR_W-1:0] pend_addr;
        logic              resp_valid;
        logic              resp_hit;
        logic              resp_cached;
        logic [LINE_W-1:0] resp_line;
        logic [DATA_W-1:0] resp_data;
        logic              mem_valid;
        logic              mem_write;
        logic [ADDR_W-1:0] mem_addr;
        logic [DATA_W-1:0] mem_wdata;
    } ctrl_t;

    ctrl_t ct_d, ct_q;

    logic [ADDR_W-1:0]       cur_addr;
    logic [SET_W-1:0]        cur_set;
    logic [TAG_W-1:0]        cur_tag;
    logic                    accept;

    logic [1:0]              rd_valid;
    logic [1:0][TAG_W-1:0]   rd_tag;
    logic [1:0][DATA_W-1:0]  rd_data;
    logic                    lru_way;
    logic [1:0]              way_hit;
    logic                    lk_hit, lk_hit_way, lk_victim;

    logic                    wr_en, wr_way, touch_en, touch_way;
    logic [DATA_W-1:0]       wr_data;

    assign cur_addr  = (ct_q.mode == MODE_FILL) ? ct_q.pend_addr : req_addr;
    assign cur_set   = cur_addr[SET_W-1:0];
    assign cur_tag   = cur_addr[ADDR_W-1:SET_W];
    assign req_ready = (ct_q.mode == MODE_IDLE);
    assign accept    = req_valid && req_ready;

    cache2w_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_set   (cur_set),
        .wr_way   (wr_way),
        .wr_tag   (cur_tag),
        .wr_data  (wr_data),
        .rd_set   (cur_set),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data)
    );

    cache2w_lrubits #(.SETS(SETS)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_set (cur_set),
        .touch_way (touch_way),
        .rd_set    (cur_set),
        .evict_way (lru_way)
    );

    cache2w_lookup #(.TAG_W(TAG_W)) u_lookup (
        .tag        (cur_tag),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .lru_way    (lru_way),
        .way_hit    (way_hit),
        .hit        (lk_hit),
        .hit_way    (lk_hit_way),
        .victim_way (lk_victim)
    );

    always_comb begin
        ct_d            = ct_q;
        ct_d.resp_valid = 1'b0;
        ct_d.mem_valid  = 1'b0;
        wr_en           = 1'b0;
        wr_way          = 1'b0;
        wr_data         = req_wdata;
        touch_en        = 1'b0;
        touch_way       = 1'b0;

        unique case (ct_q.mode)
            MODE_IDLE: begin
                if (accept) begin
                    if (lk_hit) begin
                        touch_en         = 1'b1;
                        touch_way        = lk_hit_way;
                        ct_d.resp_valid  = 1'b1;
                        ct_d.resp_hit    = 1'b1;
                        ct_d.resp_cached = 1'b1;
                        ct_d.resp_line   = {cur_set, lk_hit_way};
                        if (req_write) begin
                            wr_en          = 1'b1;
                            wr_way         = lk_hit_way;
                            ct_d.resp_data = req_wdata;
                            ct_d.mem_valid = 1'b1;
                            ct_d.mem_write = 1'b1;
                            ct_d.mem_addr  = req_addr;
                            ct_d.mem_wdata = req_wdata;
                        end else begin
                            ct_d.resp_data = rd_data[lk_hit_way];
                        end
                    end else if (req_write) begin
                        ct_d.resp_valid  = 1'b1;
                        ct_d.resp_hit    = 1'b0;
                        ct_d.resp_cached = 1'b0;
                        ct_d.resp_line   = '0;
                        ct_d.resp_data   = req_wdata;
                        ct_d.mem_valid   = 1'b1;
                        ct_d.mem_write   = 1'b1;
                        ct_d.mem_addr    = req_addr;
                        ct_d.mem_wdata   = req_wdata;
                    end else begin
                        ct_d.mode      = MODE_FILL;
                        ct_d.pend_addr = req_addr;
                        ct_d.mem_valid = 1'b1;
                        ct_d.mem_write = 1'b0;
                        ct_d.mem_addr  = req_addr;
                    end
                end
            end
            MODE_FILL: begin
                if (mem_rsp_valid) begin
                    wr_en            = 1'b1;
                    wr_way           = lk_victim;
                    wr_data          = mem_rsp_data;
                    touch_en         = 1'b1;
                    touch_way        = lk_victim;
                    ct_d.resp_valid  = 1'b1;
                    ct_d.resp_hit    = 1'b0;
                    ct_d.resp_cached = 1'b1;
                    ct_d.resp_line   = {cur_set, lk_victim};
                    ct_d.resp_data   = mem_rsp_data;
                    ct_d.mode        = MODE_IDLE;
                end
            end
            default: ct_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ct_q <= '0;
        else     ct_q <= ct_d;
    end

    assign resp_valid    = ct_q.resp_valid;
    assign resp_hit      = ct_q.resp_hit;
    assign resp_cached   = ct_q.resp_cached;
    assign resp_line     = ct_q.resp_line;
    assign resp_rdata    = ct_q.resp_data;
    assign mem_req_valid = ct_q.mem_valid;
    assign mem_req_write = ct_q.mem_write;
    assign mem_req_addr  = ct_q.mem_addr;
    assign mem_req_wdata = ct_q.mem_wdata;

    // R1: the first cycle after reset carries no response and no memory traffic
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !resp_valid && !mem_req_valid && req_ready);

    // R2: a tag can match in at most one way of a set
    assert_single_way_hit_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_hit));

    // R3: a read hit answers on the next cycle with the stored word and no fetch
    assert_read_hit_next_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && lk_hit) |=>
            resp_valid && resp_hit && !mem_req_valid &&
            resp_rdata == $past(rd_data[lk_hit_way]));

    // R4: an outstanding fetch keeps the request port stalled
    assert_stall_on_fetch_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_write) |-> !req_ready);

    // R5: a fill into an empty set lands in way 0
    assert_empty_set_left_R5: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && mem_rsp_valid && rd_valid == 2'b00) |=>
            resp_valid && resp_line[0] == 1'b0);

    // R6: a fill into a half-empty set uses the empty way
    assert_half_empty_free_way_R6: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && mem_rsp_valid && $countones(rd_valid) == 1) |=>
            resp_valid && resp_line[0] == $past(rd_valid[0]));

    // R9: a write miss goes to memory without allocating
    assert_write_miss_through_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && !lk_hit) |=>
            mem_req_valid && mem_req_write && resp_valid && !resp_cached);

endmodule

// File: tb/cache2w_lru_bench.sv
module cache2w_lru_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NVEC   = 20;
    localparam int MEM_LAT = 2;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic        hit;
        logic        cached;
        logic [2:0]  line;
    } vec_t;

    // Line = set*2+way, set = addr%4 (R2)
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 8'h00, 32'h0,          1'b0, 1'b1, 3'd0}, // empty set -> way 0 (R5)
        '{1'b0, 8'h04, 32'h0,          1'b0, 1'b1, 3'd1}, // one free way (R6)
        '{1'b0, 8'h00, 32'h0,          1'b1, 1'b1, 3'd0}, // hit (R3)
        '{1'b0, 8'h08, 32'h0,          1'b0, 1'b1, 3'd1}, // evict LRU way 1 (R7)
        '{1'b0, 8'h04, 32'h0,          1'b0, 1'b1, 3'd0}, // evict LRU way 0 (R7)
        '{1'b0, 8'h05, 32'h0,          1'b0, 1'b1, 3'd2},
        '{1'b1, 8'h05, 32'h0000_00AA,  1'b1, 1'b1, 3'd2}, // write hit (R8)
        '{1'b0, 8'h05, 32'h0,          1'b1, 1'b1, 3'd2},
        '{1'b1, 8'h0D, 32'h0000_00BB,  1'b0, 1'b0, 3'd0}, // write miss (R9)
        '{1'b0, 8'h0D, 32'h0,          1'b0, 1'b1, 3'd3}, // not allocated (R9)
        '{1'b0, 8'h07, 32'h0,          1'b0, 1'b1, 3'd6},
        '{1'b0, 8'h08, 32'h0,          1'b1, 1'b1, 3'd1}, // hit refreshes LRU (R7)
        '{1'b0, 8'h10, 32'h0,          1'b0, 1'b1, 3'd0},
        '{1'b0, 8'h04, 32'h0,          1'b0, 1'b1, 3'd1},
        '{1'b0, 8'h10, 32'h0,          1'b1, 1'b1, 3'd0},
        '{1'b1, 8'h10, 32'h0000_00CC,  1'b1, 1'b1, 3'd0},
        '{1'b0, 8'h10, 32'h0,          1'b1, 1'b1, 3'd0},
        '{1'b0, 8'h02, 32'h0,          1'b0, 1'b1, 3'd4},
        '{1'b0, 8'h06, 32'h0,          1'b0, 1'b1, 3'd5},
        '{1'b0, 8'h02, 32'h0,          1'b1, 1'b1, 3'd4}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              resp_valid, resp_hit, resp_cached;
    logic [2:0]        resp_line;
    logic [DATA_W-1:0] resp_rdata;
    logic              mem_req_valid, mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    logic [DATA_W-1:0] ram     [0:255];
    logic [DATA_W-1:0] exp_mem [0:255];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cache2w_lru #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(4)) u_cache2w_lru (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_wdata     (req_wdata),
        .resp_valid    (resp_valid),
        .resp_hit      (resp_hit),
        .resp_cached   (resp_cached),
        .resp_line     (resp_line),
        .resp_rdata    (resp_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: answers fetches MEM_LAT negedges after seeing them
    initial begin
        int cnt = 0;
        logic [ADDR_W-1:0] raddr = '0;
        for (int i = 0; i < 256; i++) begin
            ram[i]     = 32'hD000_0000 | i;
            exp_mem[i] = 32'hD000_0000 | i;
        end
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt != 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = ram[raddr];
                end
            end
            if (mem_req_valid) begin
                if (mem_req_write) ram[mem_req_addr] = mem_req_wdata;
                else begin
                    raddr = mem_req_addr;
                    cnt   = MEM_LAT;
                end
            end
        end
    end

    task automatic access(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                          input logic exp_hit, input logic exp_cached, input logic [2:0] exp_line);
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            exp_mem[addr] = wd;
            // R8 / R9: write-through issued the cycle after acceptance
            chk(mem_req_valid && mem_req_write && mem_req_addr == addr &&
                mem_req_wdata == wd, "R8", "write-through request",
                {mem_req_valid, mem_req_write, 22'd0, mem_req_addr}, {2'b11, 22'd0, addr});
        end else if (!exp_hit) begin
            // R4: fetch issued and port stalled
            chk(!req_ready && mem_req_valid && !mem_req_write && mem_req_addr == addr,
                "R4", "miss fetch/stall", {req_ready, mem_req_valid, 22'd0, mem_req_addr},
                {2'b01, 22'd0, addr});
        end else begin
            // R3: no fetch on a read hit
            chk(!mem_req_valid, "R3", "no fetch on hit", 32'(mem_req_valid), 32'd0);
        end
        while (!resp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(resp_valid, "R4", "response present", 32'(resp_valid), 32'd1);
        if (!wr && !exp_hit)
            chk(n == MEM_LAT + 1, "R4", "miss latency", 32'(n), 32'(MEM_LAT + 1));
        if (wr || exp_hit)
            chk(n == 0, "R3", "hit latency", 32'(n), 32'd0);
        chk(resp_hit == exp_hit, "R7", "hit flag", 32'(resp_hit), 32'(exp_hit));
        chk(resp_cached == exp_cached, "R9", "cached flag", 32'(resp_cached), 32'(exp_cached));
        if (exp_cached)
            chk(resp_line == exp_line, "R2", "line number", 32'(resp_line), 32'(exp_line));
        chk(resp_rdata == exp_mem[addr], "R3", "data", resp_rdata, exp_mem[addr]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        do_reset();
        // R1: idle state after reset
        chk(req_ready && !resp_valid && !mem_req_valid, "R1", "reset outputs",
            {29'd0, req_ready, resp_valid, mem_req_valid}, 32'd4);

        for (int i = 0; i < NVEC; i++)
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata,
                   VECS[i].hit, VECS[i].cached, VECS[i].line);

        // R10: mid-run reset empties lines and clears LRU bits
        do_reset();
        chk(req_ready && !resp_valid, "R10", "ready after reset",
            {30'd0, req_ready, resp_valid}, 32'd2);
        access(1'b0, 8'h10, 32'h0, 1'b0, 1'b1, 3'd0); // R10 was resident, now misses; R5
        access(1'b0, 8'h14, 32'h0, 1'b0, 1'b1, 3'd1); // R6
        access(1'b0, 8'h10, 32'h0, 1'b1, 1'b1, 3'd0); // hit way 0, LRU -> way 1
        access(1'b0, 8'h18, 32'h0, 1'b0, 1'b1, 3'd1); // R7 evicts way 1
        access(1'b0, 8'h10, 32'h0, 1'b1, 1'b1, 3'd0); // R7 survivor still hits
        // R1: first access to another set after reset misses into way 0
        access(1'b0, 8'h03, 32'h0, 1'b0, 1'b1, 3'd6);

        finish_run();
    end

endmodule